// File: doc/BRIEF.md
# SDRAM Command Issuer with Refresh Preemption

This block sits on the controller side of an SDRAM interface. It accepts one request at a time over a valid/ready handshake and turns it into the four active-low command pins, the bank address and the 11-bit address bus. The supported request kinds are row activate, column read, column write, precharge, mode-register load and burst stop. Every pin is registered, so a command accepted on a rising edge is driven on the pins from that edge until the next one.

The block keeps the open or closed state of each bank and refuses requests that the memory would not accept. A refused request is still consumed. It raises a one-cycle error pulse and the pins carry a no-operation for that cycle. An internal timer counts a programmable number of clock cycles. When it expires, the block closes any open rows with a precharge-all and then issues an auto refresh. While that refresh is pending or in progress it holds `req_ready` low.

Back-pressure rules: a request transfers on a rising edge where both `req_valid` and `req_ready` are high. The request fields must stay stable while `req_valid` is high and `req_ready` is low. `req_ready` does not depend on `req_valid`.

Top module: `sdram_cmd_issuer`

## Requirements
- R1: While `rst_n` is low, `cmd_cs_n`, `cmd_ras_n`, `cmd_cas_n` and `cmd_we_n` are all high, `cmd_a` and `cmd_ba` are zero, `bank_open` is zero and `req_err` is low.
- R2: After reset, every cycle without an accepted legal request or refresh action drives NOP: CS#,RAS#,CAS#,WE# = 0,1,1,1, with `cmd_a` and `cmd_ba` zero.
- R3: An accepted `req_op`=0 (activate) to a closed bank drives 0,0,1,1, with `cmd_ba` set to the bank and `cmd_a` set to the row, on the cycle after acceptance. That bank's bit in `bank_open` is then set.
- R4: An accepted `req_op`=1 (read) or 2 (write) to an open bank drives 0,1,0,1 or 0,1,0,0 respectively. `cmd_a[7:0]` carries the column and `cmd_a[8]` carries the auto-precharge flag; `cmd_a[10:9]` are zero. When `cmd_a[8]` is high, the bank is closed afterwards.
- R5: An accepted `req_op`=3 (precharge) drives 0,0,1,0. If `req_addr[8]` is low, only the given bank is closed and `cmd_ba` carries it. If `req_addr[8]` is high, all banks are closed, `cmd_a` is exactly bit 8 set and `cmd_ba` is zero.
- R6: `req_op`=4 (mode load) with bank code 0 or 1 drives 0,0,0,0 with the opcode on `cmd_a` and the bank code on `cmd_ba`. Bank codes 2 and 3 are refused.
- R7: `req_op`=5 (burst stop) drives 0,1,1,0 only if the last burst command was a read without auto precharge. It is refused after a write, after a read with auto precharge, and after any precharge, refresh or mode load.
- R8: An activate to an open bank, or a read or write to a closed bank, is refused: `req_err` is high and the pins show NOP in the cycle after acceptance, and `bank_open` is unchanged.
- R9: With all banks closed, an auto refresh (0,0,0,1, `cmd_a` and `cmd_ba` zero) appears every REFRESH_CYCLES cycles.
- R10: If any bank is open when a refresh falls due, a precharge with `cmd_a[8]` high is driven, and the auto refresh follows on the next cycle. All banks are closed when the refresh is driven.
- R11: `req_ready` is low from the cycle a refresh falls due until the auto refresh is on the pins. A request held valid across this window is issued afterwards, unchanged.
- R12: The reserved `req_op` codes 6 and 7 are refused with `req_err` and NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands change on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 3 | Request kind: 0 act, 1 read, 2 write, 3 precharge, 4 mode load, 5 burst stop |
| req_bank | input | 2 | Target bank, or mode-register select |
| req_addr | input | 11 | Row, column plus bit-8 flag, or opcode |
| req_err | output | 1 | One-cycle pulse: the last accepted request was refused |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | 2 | Bank address pins |
| cmd_a | output | 11 | Address pins |
| bank_open | output | 4 | One bit per bank, set while its row is open |

## Verification
The bound checker watches four properties on every cycle. Chip select stays low once out of reset. A refused request always shows NOP. No activate reaches a bank that was open, and no read, write or refresh reaches a bank in the wrong state. `req_ready` stays low whenever a refresh is due. Some behaviour only the directed scenarios can show: the exact field placement of each command, the cycle on which a refresh lands relative to the previous one, the precharge-all then refresh ordering, a held request emerging intact after a refresh, and the burst-stop history rule.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  typedef enum logic [2:0] {
    OP_ACT  = 3'd0,
    OP_RD   = 3'd1,
    OP_WR   = 3'd2,
    OP_PRE  = 3'd3,
    OP_LMR  = 3'd4,
    OP_BST  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } req_op_e;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_BST, CMD_PRE, CMD_REF, CMD_LMR
  } cmd_e;

  typedef enum logic {ST_RUN, ST_REF} seq_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  function automatic pins_t encode_cmd(cmd_e c);
    pins_t p;
    case (c)
      CMD_ACT: p = 4'b0011;
      CMD_RD:  p = 4'b0101;
      CMD_WR:  p = 4'b0100;
      CMD_BST: p = 4'b0110;
      CMD_PRE: p = 4'b0010;
      CMD_REF: p = 4'b0001;
      CMD_LMR: p = 4'b0000;
      default: p = 4'b0111;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sdram_req_check.sv
module sdram_req_check
  import sdram_cmd_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int BA_W  = $clog2(BANKS)
) (
  input  logic [2:0]      op_raw,
  input  logic [BA_W-1:0] bank,
  input  logic [BANKS-1:0] open_q,
  input  logic            burst_stoppable,
  output logic            legal,
  output cmd_e            cmd
);
  req_op_e op;
  logic    bank_is_open;

  assign op           = req_op_e'(op_raw);
  assign bank_is_open = open_q[bank];

  always_comb begin
    legal = 1'b0;
    cmd   = CMD_NOP;
    case (op)
      OP_ACT: begin legal = !bank_is_open; cmd = CMD_ACT; end
      OP_RD:  begin legal = bank_is_open;  cmd = CMD_RD;  end
      OP_WR:  begin legal = bank_is_open;  cmd = CMD_WR;  end
      OP_PRE: begin legal = 1'b1;          cmd = CMD_PRE; end
      OP_LMR: begin legal = (bank < BA_W'(2)); cmd = CMD_LMR; end
      OP_BST: begin legal = burst_stoppable; cmd = CMD_BST; end
      default: begin legal = 1'b0; cmd = CMD_NOP; end
    endcase
  end
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_cmd_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int BA_W  = $clog2(BANKS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  cmd_e            issue_cmd,
  input  logic [BA_W-1:0] issue_bank,
  input  logic            issue_flag,
  output logic [BANKS-1:0] open_q,
  output logic            burst_stoppable
);
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (issue_bank == BA_W'(b));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q[b] <= 1'b0;
      end else begin
        case (issue_cmd)
          CMD_ACT: if (hit) open_q[b] <= 1'b1;
          CMD_RD, CMD_WR: if (hit && issue_flag) open_q[b] <= 1'b0;
          CMD_PRE: if (hit || issue_flag) open_q[b] <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_stoppable <= 1'b0;
    end else begin
      case (issue_cmd)
        CMD_RD:  burst_stoppable <= !issue_flag;
        CMD_WR, CMD_BST, CMD_PRE, CMD_REF, CMD_LMR: burst_stoppable <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int INTERVAL = 780,
  parameter int CNT_W    = $clog2(INTERVAL)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic serviced,
  output logic due
);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt;
  logic             expire;

  assign expire = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= RELOAD;
      due <= 1'b0;
    end else begin
      cnt <= expire ? RELOAD : cnt - 1'b1;
      due <= expire | (due & ~serviced);
    end
  end
endmodule

// File: rtl/sdram_cmd_issuer.sv
module sdram_cmd_issuer
  import sdram_cmd_pkg::*;
#(
  parameter int REFRESH_CYCLES = 780,
  parameter int BANKS          = 4,
  parameter int ROW_W          = 11,
  parameter int COL_W          = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [2:0]               req_op,
  input  logic [$clog2(BANKS)-1:0] req_bank,
  input  logic [ROW_W-1:0]         req_addr,
  output logic                     req_err,
  output logic                     cmd_cs_n,
  output logic                     cmd_ras_n,
  output logic                     cmd_cas_n,
  output logic                     cmd_we_n,
  output logic [$clog2(BANKS)-1:0] cmd_ba,
  output logic [ROW_W-1:0]         cmd_a,
  output logic [BANKS-1:0]         bank_open
);
  localparam int BA_W   = $clog2(BANKS);
  localparam int FLAG_B = COL_W;
  localparam logic [ROW_W-1:0] COL_MASK  = {{(ROW_W-FLAG_B-1){1'b0}}, {(FLAG_B+1){1'b1}}};
  localparam logic [ROW_W-1:0] FLAG_ONLY = {{(ROW_W-FLAG_B-1){1'b0}}, 1'b1, {FLAG_B{1'b0}}};

  seq_e             seq_q, seq_d;
  logic             refresh_due, refresh_done;
  logic             req_legal, stoppable;
  cmd_e             req_cmd, nxt_cmd;
  logic [BA_W-1:0]  nxt_ba;
  logic [ROW_W-1:0] nxt_a;
  logic             nxt_err;
  pins_t            nxt_pins;

  sdram_refresh_timer #(.INTERVAL(REFRESH_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .serviced(refresh_done), .due(refresh_due)
  );

  sdram_req_check #(.BANKS(BANKS)) u_check (
    .op_raw(req_op), .bank(req_bank), .open_q(bank_open),
    .burst_stoppable(stoppable), .legal(req_legal), .cmd(req_cmd)
  );

  sdram_bank_tracker #(.BANKS(BANKS)) u_banks (
    .clk(clk), .rst_n(rst_n), .issue_cmd(nxt_cmd), .issue_bank(nxt_ba),
    .issue_flag(nxt_a[FLAG_B]), .open_q(bank_open), .burst_stoppable(stoppable)
  );

  assign req_ready = (seq_q == ST_RUN) && !refresh_due;

  always_comb begin
    nxt_cmd      = CMD_NOP;
    nxt_ba       = '0;
    nxt_a        = '0;
    nxt_err      = 1'b0;
    refresh_done = 1'b0;
    seq_d        = seq_q;
    if (seq_q == ST_REF) begin
      nxt_cmd      = CMD_REF;
      refresh_done = 1'b1;
      seq_d        = ST_RUN;
    end else if (refresh_due) begin
      if (|bank_open) begin
        nxt_cmd = CMD_PRE;
        nxt_a   = FLAG_ONLY;
        seq_d   = ST_REF;
      end else begin
        nxt_cmd      = CMD_REF;
        refresh_done = 1'b1;
      end
    end else if (req_valid) begin
      if (!req_legal) begin
        nxt_err = 1'b1;
      end else begin
        nxt_cmd = req_cmd;
        case (req_cmd)
          CMD_ACT, CMD_LMR: begin nxt_ba = req_bank; nxt_a = req_addr; end
          CMD_RD, CMD_WR:   begin nxt_ba = req_bank; nxt_a = req_addr & COL_MASK; end
          CMD_PRE: begin
            nxt_a  = req_addr & FLAG_ONLY;
            nxt_ba = req_addr[FLAG_B] ? '0 : req_bank;
          end
          default: ;
        endcase
      end
    end
  end

  assign nxt_pins = encode_cmd(nxt_cmd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q     <= ST_RUN;
      cmd_cs_n  <= 1'b1;
      cmd_ras_n <= 1'b1;
      cmd_cas_n <= 1'b1;
      cmd_we_n  <= 1'b1;
      cmd_ba    <= '0;
      cmd_a     <= '0;
      req_err   <= 1'b0;
    end else begin
      seq_q     <= seq_d;
      cmd_cs_n  <= nxt_pins.cs_n;
      cmd_ras_n <= nxt_pins.ras_n;
      cmd_cas_n <= nxt_pins.cas_n;
      cmd_we_n  <= nxt_pins.we_n;
      cmd_ba    <= nxt_ba;
      cmd_a     <= nxt_a;
      req_err   <= nxt_err;
    end
  end
endmodule

// File: rtl/sdram_cmd_issuer_chk.sv
module sdram_cmd_issuer_chk #(
  parameter int BANKS = 4,
  parameter int BA_W  = $clog2(BANKS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             req_err,
  input logic             refresh_due,
  input logic             cmd_cs_n,
  input logic             cmd_ras_n,
  input logic             cmd_cas_n,
  input logic             cmd_we_n,
  input logic [BA_W-1:0]  cmd_ba,
  input logic [BANKS-1:0] bank_open
);
  logic [3:0]       pins;
  logic [BANKS-1:0] prev_open;
  logic             live;

  assign pins = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_open <= '0;
      live      <= 1'b0;
    end else begin
      prev_open <= bank_open;
      live      <= 1'b1;
    end
  end

  a_r2_selected: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> !cmd_cs_n);

  a_r8_refused_is_nop: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> pins == 4'b0111);

  a_r3_act_to_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (live && pins == 4'b0011) |-> !prev_open[cmd_ba]);

  a_r4_rw_to_open: assert property (@(posedge clk) disable iff (!rst_n)
    (live && (pins == 4'b0101 || pins == 4'b0100)) |-> prev_open[cmd_ba]);

  a_r10_refresh_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (live && pins == 4'b0001) |-> prev_open == '0);

  a_r11_due_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_due |-> !req_ready);
endmodule

bind sdram_cmd_issuer sdram_cmd_issuer_chk #(.BANKS(BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_err(req_err),
  .refresh_due(refresh_due), .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n),
  .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n), .cmd_ba(cmd_ba),
  .bank_open(bank_open)
);

// File: tb/sdram_cmd_issuer_test.sv
module sdram_cmd_issuer_test;
  localparam int N = 120;
  localparam logic [3:0] P_NOP = 4'b0111, P_ACT = 4'b0011, P_RD = 4'b0101,
                         P_WR = 4'b0100, P_BST = 4'b0110, P_PRE = 4'b0010,
                         P_REF = 4'b0001, P_LMR = 4'b0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [1:0] req_bank = '0;
  logic [10:0] req_addr = '0;
  logic req_ready, req_err, cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
  logic [1:0] cmd_ba;
  logic [10:0] cmd_a;
  logic [3:0] bank_open;
  int checks = 0, fails = 0, cyc = 0;

  sdram_cmd_issuer #(.REFRESH_CYCLES(N)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_bank(req_bank), .req_addr(req_addr), .req_err(req_err),
    .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
    .cmd_we_n(cmd_we_n), .cmd_ba(cmd_ba), .cmd_a(cmd_a), .bank_open(bank_open)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [3:0] pins();
    return {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(input int op, input int bank, input int addr);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = 3'(op); req_bank = 2'(bank); req_addr = 11'(addr);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_ref(output int c0);
    @(negedge clk);
    while (pins() != P_REF) @(negedge clk);
    c0 = cyc;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 pins in reset", pins(), 4'hF);
    chk("R1 addr in reset", {cmd_ba, cmd_a}, 0);
    chk("R1 banks in reset", bank_open, 0);
    chk("R1 err in reset", req_err, 0);
  endtask

  task automatic t_idle();
    int c0;
    wait_ref(c0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 idle nop", pins(), P_NOP);
      chk("R2 idle addr", {cmd_ba, cmd_a}, 0);
    end
  endtask

  task automatic t_act_rw();
    int c0;
    wait_ref(c0);
    issue(0, 2, 11'h5A5);
    chk("R3 act pins", pins(), P_ACT);
    chk("R3 act ba", cmd_ba, 2);
    chk("R3 act row", cmd_a, 11'h5A5);
    chk("R3 bank open", bank_open, 4'b0100);
    issue(1, 2, 11'h63C);
    chk("R4 read pins", pins(), P_RD);
    chk("R4 read col", cmd_a, 11'h03C);
    chk("R4 read keeps open", bank_open, 4'b0100);
    issue(2, 2, 11'h181);
    chk("R4 write pins", pins(), P_WR);
    chk("R4 write col ap", cmd_a, 11'h181);
    chk("R4 ap closes", bank_open, 0);
  endtask

  task automatic t_pre();
    int c0;
    wait_ref(c0);
    issue(0, 0, 1); issue(0, 1, 2);
    chk("R5 two open", bank_open, 4'b0011);
    issue(3, 1, 0);
    chk("R5 pre pins", pins(), P_PRE);
    chk("R5 pre single ba", cmd_ba, 1);
    chk("R5 pre single a", cmd_a, 0);
    chk("R5 single closes one", bank_open, 4'b0001);
    issue(0, 3, 7);
    issue(3, 2, 11'h7FF);
    chk("R5 pre all pins", pins(), P_PRE);
    chk("R5 pre all a", cmd_a, 11'h100);
    chk("R5 pre all ba", cmd_ba, 0);
    chk("R5 all closed", bank_open, 0);
  endtask

  task automatic t_lmr();
    int c0;
    wait_ref(c0);
    issue(4, 0, 11'h033);
    chk("R6 lmr pins", pins(), P_LMR);
    chk("R6 lmr opcode", cmd_a, 11'h033);
    chk("R6 lmr ba0", cmd_ba, 0);
    issue(4, 1, 11'h002);
    chk("R6 ext lmr ba1", {pins(), cmd_ba}, {P_LMR, 2'd1});
    issue(4, 2, 11'h002);
    chk("R6 reserved 2 err", {req_err, pins()}, {1'b1, P_NOP});
    issue(4, 3, 11'h002);
    chk("R6 reserved 3 err", {req_err, pins()}, {1'b1, P_NOP});
  endtask

  task automatic t_bst();
    int c0;
    wait_ref(c0);
    issue(0, 0, 5);
    issue(1, 0, 8);
    issue(5, 0, 0);
    chk("R7 bst after read", {req_err, pins()}, {1'b0, P_BST});
    issue(2, 0, 8);
    issue(5, 0, 0);
    chk("R7 bst after write", {req_err, pins()}, {1'b1, P_NOP});
    issue(1, 0, 11'h108);
    issue(5, 0, 0);
    chk("R7 bst after ap read", {req_err, pins()}, {1'b1, P_NOP});
    chk("R7 ap read closed", bank_open, 0);
  endtask

  task automatic t_illegal();
    int c0;
    wait_ref(c0);
    issue(0, 1, 9);
    issue(0, 1, 9);
    chk("R8 act open err", {req_err, pins()}, {1'b1, P_NOP});
    chk("R8 banks unchanged", bank_open, 4'b0010);
    issue(1, 2, 4);
    chk("R8 read closed err", {req_err, pins()}, {1'b1, P_NOP});
    issue(2, 3, 4);
    chk("R8 write closed err", {req_err, pins()}, {1'b1, P_NOP});
    chk("R8 banks still", bank_open, 4'b0010);
    issue(6, 1, 0);
    chk("R12 op6 err", {req_err, pins()}, {1'b1, P_NOP});
    issue(7, 1, 0);
    chk("R12 op7 err", {req_err, pins()}, {1'b1, P_NOP});
    @(negedge clk);
    chk("R8 err one cycle", req_err, 0);
    issue(3, 0, 11'h100);
  endtask

  task automatic t_refresh_idle();
    int c0;
    wait_ref(c0);
    chk("R9 no banks", bank_open, 0);
    while (cyc < c0 + N - 1) @(negedge clk);
    chk("R11 not ready when due", req_ready, 0);
    chk("R9 nop before refresh", pins(), P_NOP);
    @(negedge clk);
    chk("R9 refresh interval", pins(), P_REF);
    chk("R9 refresh addr", {cmd_ba, cmd_a}, 0);
  endtask

  task automatic t_refresh_open();
    int c0;
    wait_ref(c0);
    issue(0, 2, 3);
    while (cyc < c0 + N - 1) @(negedge clk);
    chk("R11 ready low due", req_ready, 0);
    req_valid = 1'b1; req_op = 3'd0; req_bank = 2'd1; req_addr = 11'h2AA;
    @(negedge clk);
    chk("R10 pre all first", {pins(), cmd_a[8]}, {P_PRE, 1'b1});
    chk("R11 ready low in seq", req_ready, 0);
    @(negedge clk);
    chk("R10 refresh follows", pins(), P_REF);
    chk("R10 banks closed", bank_open, 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 held request issued", {pins(), cmd_ba, cmd_a}, {P_ACT, 2'd1, 11'h2AA});
    issue(3, 0, 11'h100);
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_idle();
    t_act_rw();
    t_pre();
    t_lmr();
    t_bst();
    t_illegal();
    t_refresh_idle();
    t_refresh_open();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule